// File: doc/BRIEF.md
# Gated 16-bit Event Timer

This block is a 16-bit up-counter for a microcontroller-style peripheral set. Counting events come from a clock path: a choice of clock source (a divided instruction clock, the system clock itself, or an external pin), an optional resynchroniser to the system clock, and a power-of-two prescaler. A separate gate path only decides whether a clock-path event may advance the counter. The gate never produces a count on its own.

The gate path picks one of several sources: a gate pin, a second gate pin, or the one-system-clock-wide overflow pulse of a companion 8-bit timer. It applies a polarity choice. It can optionally turn the source into a toggled level, or open for exactly one active period after software arms it. The qualified gate level is readable as a status bit. A rollover from 0xFFFF to 0x0000 sets a sticky flag. Software clears the flag with a dedicated strobe.

Software writes two 8-bit configuration registers through a shared data port, and it can preload the counter. A typical use counts overflows of the companion timer. The clock path is set to the unsynchronised system clock, and the gate is set to the overflow pulse, active high. Each pulse then lets exactly one system-clock edge through.

Top module: `gated_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, both registers are 0, and the gate status read-back `gctl_o` equals 0x04. With polarity 0 (active low) the qualified gate is 1.
- R2: Control byte layout: [7:6] clock source (00 instruction clock = system clock/4, 01 system clock, 10 clock pin, 11 clock pin qualified by bit 3), [5:4] prescale, [3] oscillator enable, [2] sync-disable, [0] timer on. With 0x41 (system clock, synchronised, on), the synchroniser output is constant and the count never advances.
- R3: With 0x45 (system clock, sync disabled) the count advances by one on every system clock. With the instruction clock (0x01 or 0x05) it advances once every 4 system clocks.
- R4: With the clock pin selected, the count advances once per rising edge of the pin, both with sync (0x81) and without it (0x85).
- R5: Prescale field p advances the count once every 2^p clock-path events. A counter or control write restarts the prescaler.
- R6: Gate byte layout: [7] enable, [6] polarity (1 = active high), [5] toggle, [4] single-pulse, [3] go, [2] status (read only), [1:0] source (00 gate pin, 01 companion overflow, 10 second gate pin, 11 constant 0). With 0xC1, the count advances once per one-cycle overflow pulse.
- R7: With polarity 0 (0x81), counting is allowed only while the selected gate source is 0.
- R8: In toggle mode (0xE1), the gate level flips on each rising edge of the source. The count advances from the edge after the first pulse up to and including the edge of the second pulse.
- R9: In single-pulse mode with go written 1 (0xD8), the gate opens on the next active edge and closes on the following inactive edge. Go then reads 0, and later gate pulses are not counted.
- R10: `gate_val_o` and `gctl_o[2]` show the qualified gate level, including the polarity.
- R11: With timer-on 0 the count holds. With gate enable 0 the gate never blocks counting.
- R12: Rollover from 0xFFFF to 0x0000 sets `ovf_flag_o`, which stays set until `flag_clr_i` is pulsed.
- R13: `tmr_wr_i` loads `tmr_wdata_i` into the counter on the next edge, taking priority over a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| gctl_wr_i | input | 1 | Write strobe for the gate byte |
| cfg_wdata_i | input | 8 | Shared configuration write data |
| tmr_wr_i | input | 1 | Counter preload strobe |
| tmr_wdata_i | input | 16 | Counter preload value |
| flag_clr_i | input | 1 | Clears the rollover flag |
| clk_pin_i | input | 1 | External clock pin |
| gate_pin_i | input | 1 | Primary gate pin |
| gate_alt_i | input | 1 | Second gate pin |
| cmp_ovf_i | input | 1 | Companion 8-bit timer overflow pulse |
| cnt_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Sticky rollover flag |
| gate_val_o | output | 1 | Qualified gate level |
| gctl_o | output | 8 | Gate byte read-back with go and status bits |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two synchroniser stages, a divide-by-4 instruction clock and a two-bit prescale field. The prescaler can therefore reach 1:8, so prescale is checked at 1:4 and 1:8 within 16-cycle windows. Counter preload brings the 0xFFFF rollover within a few cycles. Two synchroniser stages fix the pin-to-gate latency, so windows are chosen so that the measured count does not depend on it.

// File: rtl/gtmr_pkg.sv
// Shared encodings for the gated timer: register bit positions and
// source selections. Assumes 8-bit configuration bytes.
package gtmr_pkg;
    // control byte bit positions
    localparam int CB_SRC_HI = 7;
    localparam int CB_SRC_LO = 6;
    localparam int CB_PS_HI  = 5;
    localparam int CB_PS_LO  = 4;
    localparam int CB_OSC    = 3;
    localparam int CB_NOSYNC = 2;
    localparam int CB_ON     = 0;
    // gate byte bit positions
    localparam int GB_EN  = 7;
    localparam int GB_POL = 6;
    localparam int GB_TOG = 5;
    localparam int GB_SP  = 4;
    localparam int GB_GO  = 3;
    localparam int GB_SRC_HI = 1;
    localparam int GB_SRC_LO = 0;

    typedef enum logic [1:0] {
        CS_INSTR = 2'b00,
        CS_SYS   = 2'b01,
        CS_PIN   = 2'b10,
        CS_OSC   = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        GS_PIN  = 2'b00,
        GS_OVF  = 2'b01,
        GS_ALT  = 2'b10,
        GS_ZERO = 2'b11
    } gate_src_e;
endpackage

// File: rtl/gtmr_clk_path.sv
// Clock path: selects a clock source, optionally resynchronises it to
// clk, detects rising edges and divides them by a power-of-two prescaler.
// Emits a one-cycle pulse for each event that may advance the counter.
// Assumes SYNC_STAGES >= 2. The system-clock source seen through the
// synchroniser is a constant level and so yields no events.
module gtmr_clk_path
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2,
    parameter int PS_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            osc_en_i,
    input  logic            nosync_i,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic            pin_i,
    output logic            pulse_o
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0]       ph_q;
    logic [SYNC_STAGES-1:0] sy_q;
    logic                   sy_prev_q;
    logic                   pin_prev_q;
    logic                   lvl_raw;
    logic                   tick_async;
    logic                   tick;
    logic [PRE_W-1:0]       pre_q;
    logic [PRE_W:0]         one_sh;
    logic [PRE_W-1:0]       lim;

    // free-running divider that forms the instruction clock
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_q + DIV_W'(1);
    end

    // level of the selected source as the synchroniser sees it
    always_comb begin
        case (src_i)
            CS_INSTR: lvl_raw = ph_q[DIV_W-1];
            CS_SYS:   lvl_raw = 1'b1;
            CS_PIN:   lvl_raw = pin_i;
            default:  lvl_raw = pin_i & osc_en_i;
        endcase
    end

    // resynchroniser chain plus edge-history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy_q       <= '0;
            sy_prev_q  <= 1'b0;
            pin_prev_q <= 1'b0;
        end else begin
            sy_q       <= {sy_q[SYNC_STAGES-2:0], lvl_raw};
            sy_prev_q  <= sy_q[SYNC_STAGES-1];
            pin_prev_q <= pin_i;
        end
    end

    // event detection when the synchroniser is bypassed
    always_comb begin
        case (src_i)
            CS_INSTR: tick_async = (ph_q == '1);
            CS_SYS:   tick_async = 1'b1;
            CS_PIN:   tick_async = pin_i & ~pin_prev_q;
            default:  tick_async = osc_en_i & pin_i & ~pin_prev_q;
        endcase
    end

    // pick the event stream and compute the prescale limit
    always_comb begin
        tick   = nosync_i ? tick_async : (sy_q[SYNC_STAGES-1] & ~sy_prev_q);
        one_sh = (PRE_W+1)'(1) << ps_i;
        lim    = PRE_W'(one_sh - (PRE_W+1)'(1));
    end

    // prescaler counts enabled events and wraps at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)              pre_q <= '0;
        else if (clr_i)          pre_q <= '0;
        else if (tick && en_i)   pre_q <= (pre_q == lim) ? '0 : pre_q + PRE_W'(1);
    end

    assign pulse_o = tick & en_i & (pre_q == lim);

    // R5: the prescaler never runs past its limit
    p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (pre_q <= lim));
endmodule

// File: rtl/gtmr_gate_path.sv
// Gate path: selects a gate source, applies toggle mode and polarity and
// runs single-pulse capture. Produces the qualified gate level and
// the live go bit. A gate-byte write clears the toggle and single-pulse
// state. Pin sources are resynchronised. The companion overflow
// pulse is already synchronous and is used directly.
module gtmr_gate_path
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       go_set_i,
    input  logic       pol_i,
    input  logic       tog_i,
    input  logic       sp_i,
    input  logic [1:0] src_i,
    input  logic       pin_i,
    input  logic       alt_i,
    input  logic       ovf_i,
    output logic       gval_o,
    output logic       go_o
);
    logic [SYNC_STAGES-1:0] pin_sy_q;
    logic [SYNC_STAGES-1:0] alt_sy_q;
    logic src_lvl, src_prev_q, src_rise;
    logic tff_q, base, lvl, lvl_prev_q, lvl_rise;
    logic go_q, open_q;

    // synchronise both gate pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sy_q <= '0;
            alt_sy_q <= '0;
        end else begin
            pin_sy_q <= {pin_sy_q[SYNC_STAGES-2:0], pin_i};
            alt_sy_q <= {alt_sy_q[SYNC_STAGES-2:0], alt_i};
        end
    end

    // source select, toggle substitution and polarity
    always_comb begin
        case (src_i)
            GS_PIN:  src_lvl = pin_sy_q[SYNC_STAGES-1];
            GS_OVF:  src_lvl = ovf_i;
            GS_ALT:  src_lvl = alt_sy_q[SYNC_STAGES-1];
            default: src_lvl = 1'b0;
        endcase
        src_rise = src_lvl & ~src_prev_q;
        base     = tog_i ? tff_q : src_lvl;
        lvl      = pol_i ? base : ~base;
        lvl_rise = lvl & ~lvl_prev_q;
    end

    // edge history and toggle flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev_q <= 1'b0;
            lvl_prev_q <= 1'b0;
            tff_q      <= 1'b0;
        end else begin
            src_prev_q <= src_lvl;
            lvl_prev_q <= lvl;
            if (wr_i)                  tff_q <= 1'b0;
            else if (tog_i && src_rise) tff_q <= ~tff_q;
        end
    end

    // single-pulse arm, open and close sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            open_q <= 1'b0;
        end else if (wr_i) begin
            go_q   <= go_set_i;
            open_q <= 1'b0;
        end else if (sp_i) begin
            if (!open_q && go_q && lvl_rise) begin
                open_q <= 1'b1;
            end else if (open_q && !lvl) begin
                open_q <= 1'b0;
                go_q   <= 1'b0;
            end
        end
    end

    assign gval_o = sp_i ? (lvl & (open_q | (go_q & lvl_rise))) : lvl;
    assign go_o   = go_q;

    // R9: an open single-pulse window always belongs to an armed go
    p_open_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> go_q);
    // R9: closing the window drops go on the next edge
    p_go_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_i && open_q && !lvl && !wr_i) |=> !go_q);
    // R8: a source rising edge in toggle mode flips the toggle level
    p_tog_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_i && src_rise && !wr_i) |=> (tff_q != $past(tff_q)));
endmodule

// File: rtl/gtmr_counter.sv
// Counter core: loadable up-counter with a sticky rollover flag.
// A load takes priority over an increment. A rollover beats a clear
// that arrives in the same cycle.
module gtmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         clr_flag_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o
);
    logic [W-1:0] cnt_q;
    logic         flag_q;
    logic         wrap;

    assign wrap = inc_i & ~ld_i & (cnt_q == '1);

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ld_i)  cnt_q <= ld_val_i;
        else if (inc_i) cnt_q <= cnt_q + W'(1);
    end

    // sticky rollover flag
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (wrap)       flag_q <= 1'b1;
        else if (clr_flag_i) flag_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    // R3: an accepted event moves the count by exactly one
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i) |=> (cnt_q == $past(cnt_q) + W'(1)));
    // R13: a load lands on the next edge
    p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == $past(ld_val_i)));
    // R12: rollover raises the flag
    p_wrap_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i && cnt_q == '1) |=> flag_q);
    // R12: the flag holds until cleared
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_flag_i) |=> flag_q);
endmodule

// File: rtl/gated_timer.sv
// Top of the gated timer: holds the control and gate bytes, joins the
// clock path, gate path and counter core. The gate only qualifies
// clock-path events. A disabled gate or a stopped timer never lets
// the gate block an event, and a stopped timer passes none.
module gated_timer
    import gtmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2,
    parameter int CFG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic             gctl_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             tmr_wr_i,
    input  logic [CNT_W-1:0] tmr_wdata_i,
    input  logic             flag_clr_i,
    input  logic             clk_pin_i,
    input  logic             gate_pin_i,
    input  logic             gate_alt_i,
    input  logic             cmp_ovf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_flag_o,
    output logic             gate_val_o,
    output logic [CFG_W-1:0] gctl_o
);
    localparam int PS_W = CB_PS_HI - CB_PS_LO + 1;

    logic [1:0]      csrc_q;
    logic [PS_W-1:0] ps_q;
    logic            osc_q, nosync_q, on_q;
    logic            gen_q, gpol_q, gtog_q, gsp_q;
    logic [1:0]      gsrc_q;
    logic            gval, go, count_en, pulse;

    // control byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csrc_q <= '0; ps_q <= '0; osc_q <= 1'b0; nosync_q <= 1'b0; on_q <= 1'b0;
        end else if (ctl_wr_i) begin
            csrc_q   <= cfg_wdata_i[CB_SRC_HI:CB_SRC_LO];
            ps_q     <= cfg_wdata_i[CB_PS_HI:CB_PS_LO];
            osc_q    <= cfg_wdata_i[CB_OSC];
            nosync_q <= cfg_wdata_i[CB_NOSYNC];
            on_q     <= cfg_wdata_i[CB_ON];
        end
    end

    // gate byte register (go lives in the gate path)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= 1'b0; gpol_q <= 1'b0; gtog_q <= 1'b0; gsp_q <= 1'b0; gsrc_q <= '0;
        end else if (gctl_wr_i) begin
            gen_q  <= cfg_wdata_i[GB_EN];
            gpol_q <= cfg_wdata_i[GB_POL];
            gtog_q <= cfg_wdata_i[GB_TOG];
            gsp_q  <= cfg_wdata_i[GB_SP];
            gsrc_q <= cfg_wdata_i[GB_SRC_HI:GB_SRC_LO];
        end
    end

    gtmr_gate_path #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_i(gctl_wr_i), .go_set_i(cfg_wdata_i[GB_GO]),
        .pol_i(gpol_q), .tog_i(gtog_q), .sp_i(gsp_q), .src_i(gsrc_q),
        .pin_i(gate_pin_i), .alt_i(gate_alt_i), .ovf_i(cmp_ovf_i),
        .gval_o(gval), .go_o(go)
    );

    assign count_en = on_q & (~gen_q | gval);

    gtmr_clk_path #(.SYNC_STAGES(SYNC_STAGES), .DIV_W(DIV_W), .PS_W(PS_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .src_i(csrc_q), .ps_i(ps_q), .osc_en_i(osc_q),
        .nosync_i(nosync_q), .clr_i(ctl_wr_i | tmr_wr_i), .en_i(count_en),
        .pin_i(clk_pin_i), .pulse_o(pulse)
    );

    gtmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(pulse), .ld_i(tmr_wr_i),
        .ld_val_i(tmr_wdata_i), .clr_flag_i(flag_clr_i),
        .cnt_o(cnt_o), .flag_o(ovf_flag_o)
    );

    assign gate_val_o = gval;
    assign gctl_o     = {gen_q, gpol_q, gtog_q, gsp_q, go, gval, gsrc_q};

    // R11: a stopped timer holds its count
    p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !tmr_wr_i) |=> (cnt_o == $past(cnt_o)));
    // R6: an enabled but closed gate blocks every event
    p_gate_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q && !gval && !tmr_wr_i) |=> (cnt_o == $past(cnt_o)));
endmodule

// File: tb/gated_timer_tb_top.sv
module gated_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, gctl_wr = 1'b0, tmr_wr = 1'b0, flag_clr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] tdata = '0;
    logic        cpin = 1'b0, gpin = 1'b0, galt = 1'b0, ovf = 1'b0;
    logic [15:0] cnt;
    logic        flag, gval;
    logic [7:0]  gctl;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gated_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .gctl_wr_i(gctl_wr),
        .cfg_wdata_i(wdata), .tmr_wr_i(tmr_wr), .tmr_wdata_i(tdata),
        .flag_clr_i(flag_clr), .clk_pin_i(cpin), .gate_pin_i(gpin),
        .gate_alt_i(galt), .cmp_ovf_i(ovf), .cnt_o(cnt), .ovf_flag_o(flag),
        .gate_val_o(gval), .gctl_o(gctl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [7:0] c, input logic [7:0] g);
        wdata = c; ctl_wr = 1'b1; @(negedge clk);
        ctl_wr = 1'b0; wdata = g; gctl_wr = 1'b1; @(negedge clk);
        gctl_wr = 1'b0; wdata = '0;
        cyc(6);
    endtask

    task automatic load(input logic [15:0] v);
        tdata = v; tmr_wr = 1'b1; @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    // runs n cycles, raising the overflow pulse in the listed cycles
    task automatic run_pulses(input int n, input int a, input int b, input int c);
        for (int i = 0; i < n; i++) begin
            ovf = (i == a) || (i == b) || (i == c);
            @(negedge clk);
        end
        ovf = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count", cnt, 0);
        chk("R1 flag", flag, 0);
        chk("R1 gate byte", gctl, 8'h04);
        cyc(5);
        chk("R1 idle while off", cnt, 0);
    endtask

    task automatic t_sys_sync;
        cfg(8'h41, 8'h00); load(16'h0);
        cyc(20);
        chk("R2 sync system clock never counts", cnt, 0);
    endtask

    task automatic t_sys_async;
        cfg(8'h45, 8'h00); load(16'h0);
        cyc(20);
        chk("R3 system clock unsynchronised", cnt, 20);
        cfg(8'h05, 8'h00); load(16'h0);
        cyc(16);
        chk("R3 instruction clock unsynchronised", cnt, 4);
        cfg(8'h01, 8'h00); load(16'h0);
        cyc(16);
        chk("R3 instruction clock synchronised", cnt, 4);
    endtask

    task automatic t_pin(input logic [7:0] c, input string tag);
        cfg(c, 8'h00); load(16'h0);
        for (int i = 0; i < 3; i++) begin
            cpin = 1'b1; cyc(3);
            cpin = 1'b0; cyc(3);
        end
        cyc(6);
        chk(tag, cnt, 3);
    endtask

    task automatic t_prescale;
        cfg(8'h65, 8'h00); load(16'h0);
        cyc(16);
        chk("R5 prescale 1:4", cnt, 4);
        cfg(8'h75, 8'h00); load(16'h0);
        cyc(16);
        chk("R5 prescale 1:8", cnt, 2);
    endtask

    task automatic t_gate_ovf;
        cfg(8'h45, 8'hC1); load(16'h0);
        run_pulses(20, 3, 9, 15);
        chk("R6 one count per overflow pulse", cnt, 3);
        cfg(8'h45, 8'h81); load(16'h0);
        run_pulses(20, 5, 12, -1);
        chk("R7 active-low gate skips pulse cycles", cnt, 18);
        cfg(8'h45, 8'h01); load(16'h0);
        run_pulses(20, 5, 12, -1);
        chk("R11 disabled gate never blocks", cnt, 20);
    endtask

    task automatic t_toggle;
        cfg(8'h45, 8'hE1); load(16'h0);
        run_pulses(20, 0, 10, -1);
        chk("R8 toggle gate window", cnt, 10);
    endtask

    task automatic t_single;
        cfg(8'h45, 8'hD8); load(16'h0);
        chk("R9 go armed", gctl[3], 1);
        gpin = 1'b1; cyc(5);
        gpin = 1'b0; cyc(6);
        gpin = 1'b1; cyc(5);
        gpin = 1'b0; cyc(6);
        chk("R9 single pulse count", cnt, 5);
        chk("R9 go cleared", gctl[3], 0);
    endtask

    task automatic t_gate_val;
        cfg(8'h45, 8'hC0);
        gpin = 1'b1; cyc(4);
        chk("R10 active-high status", gval, 1);
        chk("R10 status bit in gate byte", gctl[2], 1);
        cfg(8'h45, 8'h80);
        chk("R10 active-low status", gval, 0);
        gpin = 1'b0; cyc(4);
        chk("R10 active-low status released", gval, 1);
    endtask

    task automatic t_off;
        cfg(8'h44, 8'h00); load(16'h1234);
        chk("R13 load value", cnt, 16'h1234);
        cyc(10);
        chk("R11 timer off holds", cnt, 16'h1234);
    endtask

    task automatic t_rollover;
        cfg(8'h45, 8'h00); load(16'hFFFE);
        cyc(3);
        chk("R12 wrapped count", cnt, 1);
        chk("R12 flag set", flag, 1);
        cyc(5);
        chk("R12 flag sticky", flag, 1);
        flag_clr = 1'b1; @(negedge clk);
        flag_clr = 1'b0;
        chk("R12 flag cleared", flag, 0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_sys_sync();
        t_sys_async();
        t_pin(8'h81, "R4 clock pin synchronised");
        t_pin(8'h85, "R4 clock pin unsynchronised");
        t_prescale();
        t_gate_ovf();
        t_toggle();
        t_single();
        t_gate_val();
        t_off();
        t_rollover();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule